// File: doc/BRIEF.md
# RISC-V Control and Status Register Unit

This block keeps the control and status registers of a small 32-bit RISC-V core and executes the CSR read-modify-write instructions against them. Each access presents a 12-bit register address, a 3-bit operation code, a 32-bit register operand and a 5-bit immediate. The unit returns the value the addressed register holds before the access, for the destination register. When the write enable is high, the new value takes effect on the next clock edge.

The register map follows the older supervisor-level layout. It has two scratch registers, the trap registers (exception PC, bad address, exception vector, cause, status), a constant thread ID and a host mailbox pair. It also has three free-running 64-bit counters, each readable as a low half and a high half. The cycle counter advances every clock. The timer-tick counter advances once per rising edge of a timer signal from another clock domain, which passes through a synchronizer first. The retired-instruction counter advances on a retire strobe.

Top module: `csr_unit`

## Requirements
- R1: `rdData` shows, in the same cycle and combinationally from `csrAddr`, the current value of the addressed register. A write takes effect at the next rising clock edge, so `rdData` is always the value the register held before the access.
- R2: With `wrEn` high and `csrOp[1:0]` = 01 (write), the operand is stored into the addressed writable register.
- R3: `csrOp[1:0]` = 10 (set) stores old OR operand. `csrOp[1:0]` = 11 (clear) stores old AND NOT operand. `csrOp[1:0]` = 00 performs no write.
- R4: `csrOp[2]` = 1 selects `immOperand` zero-extended to 32 bits as the operand. `csrOp[2]` = 0 selects `regOperand`.
- R5: A set or clear whose operand is zero performs no write. In particular, such an access leaves the from-host register (0x51F) unchanged.
- R6: The 64-bit cycle counter increments on every clock after reset. Its low half reads at 0xC00 and its high half at 0xC80.
- R7: The 64-bit timer-tick counter increments exactly once per rising edge of `timerIn`, after a two-stage synchronizer. Its low half reads at 0xC01 and its high half at 0xC81.
- R8: The 64-bit retired-instruction counter increments on each clock where `retire` is high. Its low half reads at 0xC02 and its high half at 0xC82.
- R9: The counter addresses and the thread ID (0x50B) are read-only, and writes to them are ignored. 0x50B reads as the parameter `HART_ID`.
- R10: An unmapped address reads as zero, and a write to it changes no register.
- R11: The to-host register 0x51E is writable and drives `toHost`. When `hostValid` is high, the from-host register 0x51F loads `hostData`; this takes priority over a software write in the same cycle.
- R12: 0x500 and 0x501 (scratch), 0x502 (exception PC), 0x503 (bad address), 0x508 (exception vector), 0x509 (cause) and 0x50A (status) are 32-bit read/write registers.
- R13: While `rstN` is low, all registers and counters are zero. The thread ID is a constant and is not affected by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 12 | Address of the register being accessed |
| csrOp | input | 3 | Bit 2 selects the immediate operand; bits 1:0 give the function: 00 none, 01 write, 10 set, 11 clear |
| regOperand | input | 32 | Register-sourced operand |
| immOperand | input | 5 | Immediate operand, zero-extended |
| wrEn | input | 1 | Commit the access at the next edge |
| rdData | output | 32 | Value of the addressed register before the access |
| retire | input | 1 | One instruction retired this cycle |
| timerIn | input | 1 | Timer tick level from another clock domain |
| hostValid | input | 1 | Load hostData into the from-host register |
| hostData | input | 32 | Data delivered by the host |
| toHost | output | 32 | Contents of the to-host register |

## Verification
The assertions check several rules on every cycle. The cycle counter steps by exactly one. The retire and timer counters step only on their strobes. The synchronized timer pulse lasts a single cycle. Zero-operand set and clear, read-only and unmapped addresses never raise the write strobe. A host delivery always lands in the from-host register, and the to-host register holds its value unless it is written. The read-modify-write arithmetic, the immediate zero-extension, the address map, the thread ID value, host priority over a software write and the reset values can only be shown by the bench's scenarios, which compare the returned old values against expected results.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int XLEN     = 32;
  localparam int CNT_W    = 2 * XLEN;
  localparam int ADDR_W   = 12;
  localparam int IMM_W    = 5;
  localparam int N_RW     = 9;
  localparam int RW_IDX_W = $clog2(N_RW);
  localparam int N_CNT    = 3;
  localparam int CNT_IDX_W = 2;

  localparam int TOHOST_IDX   = 7;
  localparam int FROMHOST_IDX = 8;

  localparam logic [ADDR_W-1:0] HART_ADDR = 12'h50B;

  typedef enum logic [1:0] {
    FN_NONE  = 2'b00,
    FN_WRITE = 2'b01,
    FN_SET   = 2'b10,
    FN_CLEAR = 2'b11
  } csr_fn_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrGo;
    logic                 rwHit;
    logic [RW_IDX_W-1:0]  rwIdx;
    logic                 cntHit;
    logic                 cntHigh;
    logic [CNT_IDX_W-1:0] cntIdx;
    logic                 hartHit;
    csr_fn_e              fn;
    logic [XLEN-1:0]      opVal;
  } csr_stb_t;

  // Address of each writable register, by storage slot
  function automatic logic [ADDR_W-1:0] rwAddrOf(input int idx);
    case (idx)
      0:       rwAddrOf = 12'h500;  // scratch 0
      1:       rwAddrOf = 12'h501;  // scratch 1
      2:       rwAddrOf = 12'h502;  // exception PC
      3:       rwAddrOf = 12'h503;  // bad address
      4:       rwAddrOf = 12'h508;  // exception vector
      5:       rwAddrOf = 12'h509;  // cause
      6:       rwAddrOf = 12'h50A;  // status
      7:       rwAddrOf = 12'h51E;  // to host
      default: rwAddrOf = 12'h51F;  // from host
    endcase
  endfunction
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic pulseOut
);
  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], asyncIn};
      lastQ <= syncQ[STAGES-1];
    end
  end

  assign pulseOut = syncQ[STAGES-1] & ~lastQ;

  // R7: one increment per edge, so the pulse never lasts two cycles
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |=> !pulseOut);
endmodule

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [2:0]        csrOp,
  input  logic [XLEN-1:0]   regOperand,
  input  logic [IMM_W-1:0]  immOperand,
  input  logic              wrEn,
  output csr_stb_t          stb
);
  logic effect;

  always_comb begin
    stb = '0;
    stb.opVal = csrOp[2] ? {{(XLEN-IMM_W){1'b0}}, immOperand} : regOperand;
    stb.fn    = csr_fn_e'(csrOp[1:0]);
    for (int i = 0; i < N_RW; i++) begin
      if (csrAddr == rwAddrOf(i)) begin
        stb.rwHit = 1'b1;
        stb.rwIdx = RW_IDX_W'(i);
      end
    end
    stb.cntHit  = (csrAddr[11:8] == 4'hC) && (csrAddr[6:2] == 5'd0) &&
                  (csrAddr[1:0] != 2'b11);
    stb.cntHigh = csrAddr[7];
    stb.cntIdx  = csrAddr[1:0];
    stb.hartHit = (csrAddr == HART_ADDR);
    effect = (stb.fn == FN_WRITE) ||
             (((stb.fn == FN_SET) || (stb.fn == FN_CLEAR)) && (stb.opVal != '0));
    stb.wrGo = wrEn && stb.rwHit && effect;
  end

  // R5: set/clear with zero operand never writes
  assert_zero_noop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && csrOp[1] && (csrOp[2] ? (immOperand == '0) : (regOperand == '0)))
      |-> !stb.wrGo);
  // R9: read-only addresses never write
  assert_readonly_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == HART_ADDR || csrAddr[11:8] == 4'hC) |-> !stb.wrGo);
  // R10: unmapped addresses never write
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr[11:8] != 4'h5) |-> !stb.wrGo);
endmodule

// File: rtl/csr_dpath.sv
module csr_dpath
  import csr_pkg::*;
#(
  parameter logic [XLEN-1:0] HART_ID = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  csr_stb_t        stb,
  input  logic            retire,
  input  logic            timerPulse,
  input  logic            hostValid,
  input  logic [XLEN-1:0] hostData,
  output logic [XLEN-1:0] rdData,
  output logic [XLEN-1:0] toHost
);
  logic [XLEN-1:0]  rwVal  [N_RW];
  logic [CNT_W-1:0] cntVal [N_CNT];
  logic [N_CNT-1:0] incVec;
  logic [XLEN-1:0]  oldVal;
  logic [XLEN-1:0]  nextVal;

  assign incVec = {retire, timerPulse, 1'b1};
  assign oldVal = rwVal[stb.rwIdx];

  always_comb begin
    unique case (stb.fn)
      FN_WRITE: nextVal = stb.opVal;
      FN_SET:   nextVal = oldVal | stb.opVal;
      FN_CLEAR: nextVal = oldVal & ~stb.opVal;
      default:  nextVal = oldVal;
    endcase
  end

  for (genvar g = 0; g < N_RW; g++) begin : g_rw
    logic [XLEN-1:0] q;
    if (g == FROMHOST_IDX) begin : g_host
      always_ff @(posedge clk) begin
        if (!rstN)                                        q <= '0;
        else if (hostValid)                               q <= hostData;
        else if (stb.wrGo && stb.rwIdx == RW_IDX_W'(g))   q <= nextVal;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)                                        q <= '0;
        else if (stb.wrGo && stb.rwIdx == RW_IDX_W'(g))   q <= nextVal;
      end
    end
    assign rwVal[g] = q;
  end

  for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)          q <= '0;
      else if (incVec[c]) q <= q + CNT_W'(1);
    end
    assign cntVal[c] = q;
  end

  always_comb begin
    if (stb.rwHit)
      rdData = oldVal;
    else if (stb.cntHit)
      rdData = stb.cntHigh ? cntVal[stb.cntIdx][CNT_W-1:XLEN]
                           : cntVal[stb.cntIdx][XLEN-1:0];
    else if (stb.hartHit)
      rdData = HART_ID;
    else
      rdData = '0;
  end

  assign toHost = rwVal[TOHOST_IDX];

  // R6: cycle counter steps by one every clock
  assert_cycle_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cntVal[0] == $past(cntVal[0]) + CNT_W'(1));
  // R7: timer counter steps on the synchronized pulse only
  assert_time_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    timerPulse |=> cntVal[1] == $past(cntVal[1]) + CNT_W'(1));
  assert_time_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !timerPulse |=> $stable(cntVal[1]));
  // R8: retired counter follows the retire strobe
  assert_retire_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    retire |=> cntVal[2] == $past(cntVal[2]) + CNT_W'(1));
  assert_retire_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !retire |=> $stable(cntVal[2]));
  // R11: host delivery always lands; to-host holds unless written
  assert_host_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostValid |=> rwVal[FROMHOST_IDX] == $past(hostData));
  assert_tohost_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrGo && stb.rwIdx == RW_IDX_W'(TOHOST_IDX)) |=> $stable(toHost));
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter logic [31:0] HART_ID     = 32'h0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] csrAddr,
  input  logic [2:0]  csrOp,
  input  logic [31:0] regOperand,
  input  logic [4:0]  immOperand,
  input  logic        wrEn,
  output logic [31:0] rdData,
  input  logic        retire,
  input  logic        timerIn,
  input  logic        hostValid,
  input  logic [31:0] hostData,
  output logic [31:0] toHost
);
  csr_stb_t stb;
  logic     timerPulse;

  tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (timerIn),
    .pulseOut (timerPulse)
  );

  csr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csrAddr    (csrAddr),
    .csrOp      (csrOp),
    .regOperand (regOperand),
    .immOperand (immOperand),
    .wrEn       (wrEn),
    .stb        (stb)
  );

  csr_dpath #(.HART_ID(HART_ID)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .retire     (retire),
    .timerPulse (timerPulse),
    .hostValid  (hostValid),
    .hostData   (hostData),
    .rdData     (rdData),
    .toHost     (toHost)
  );
endmodule

// File: tb/sim_csr_unit.sv
`timescale 1ns/1ps
module sim_csr_unit;
  localparam logic [31:0] HART = 32'hC0DE0007;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [2:0]  csrOp = '0;
  logic [31:0] regOperand = '0;
  logic [4:0]  immOperand = '0;
  logic        wrEn = 1'b0;
  logic [31:0] rdData;
  logic        retire = 1'b0;
  logic        timerIn = 1'b0;
  logic        hostValid = 1'b0;
  logic [31:0] hostData = '0;
  logic [31:0] toHost;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  csr_unit #(.HART_ID(HART)) u0 (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrOp(csrOp),
    .regOperand(regOperand), .immOperand(immOperand), .wrEn(wrEn),
    .rdData(rdData), .retire(retire), .timerIn(timerIn),
    .hostValid(hostValid), .hostData(hostData), .toHost(toHost)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [2:0]  op;
    logic [31:0] rv;
    logic [4:0]  iv;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{12'h500, 3'b001, 32'h12345678, 5'd0,  32'h00000000, 4'd2},  // R2 write
    '{12'h500, 3'b010, 32'h0000F000, 5'd0,  32'h12345678, 4'd3},  // R3 set
    '{12'h500, 3'b011, 32'h00000678, 5'd0,  32'h1234F678, 4'd3},  // R3 clear
    '{12'h500, 3'b101, 32'hFFFFFFFF, 5'h1F, 32'h1234F000, 4'd4},  // R4 write imm
    '{12'h500, 3'b110, 32'hFFFFFFFF, 5'h00, 32'h0000001F, 4'd5},  // R5 set imm 0
    '{12'h500, 3'b111, 32'hFFFFFFFF, 5'h03, 32'h0000001F, 4'd4},  // R4 clear imm
    '{12'h500, 3'b000, 32'hFFFFFFFF, 5'd0,  32'h0000001C, 4'd3},  // R3 fn none
    '{12'h50A, 3'b001, 32'hA5A5A5A5, 5'd0,  32'h00000000, 4'd12}, // R12 status
    '{12'h50A, 3'b110, 32'h0,        5'h1A, 32'hA5A5A5A5, 4'd4},  // R4 set imm
    '{12'h50A, 3'b000, 32'h0,        5'd0,  32'hA5A5A5BF, 4'd1},  // R1 read
    '{12'h500, 3'b000, 32'h0,        5'd0,  32'h0000001C, 4'd1},  // R1 read
    '{12'h50B, 3'b001, 32'h0000DEAD, 5'd0,  HART,         4'd9},  // R9 hart write
    '{12'h50B, 3'b000, 32'h0,        5'd0,  HART,         4'd9},  // R9 hart read
    '{12'h7C0, 3'b001, 32'h00000055, 5'd0,  32'h00000000, 4'd10}, // R10 unmapped
    '{12'h7C0, 3'b000, 32'h0,        5'd0,  32'h00000000, 4'd10}, // R10 read
    '{12'h51E, 3'b001, 32'hCAFEF00D, 5'd0,  32'h00000000, 4'd11}, // R11 tohost
    '{12'h51E, 3'b011, 32'h0000F00D, 5'd0,  32'hCAFEF00D, 4'd11}, // R11 clear
    '{12'h51E, 3'b000, 32'h0,        5'd0,  32'hCAFE0000, 4'd11}, // R11 read
    '{12'h501, 3'b101, 32'hFFFFFFFF, 5'd5,  32'h00000000, 4'd12}, // R12 scratch1
    '{12'h501, 3'b000, 32'h0,        5'd0,  32'h00000005, 4'd12}  // R12 read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample old value 1 ns later, commit at posedge
  task automatic access(input logic [11:0] a, input logic [2:0] o, input logic [31:0] r,
                        input logic [4:0] i, input logic w, output logic [31:0] old);
    @(negedge clk);
    csrAddr = a; csrOp = o; regOperand = r; immOperand = i; wrEn = w;
    #1 old = rdData;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic readCsr(input logic [11:0] a, output logic [31:0] v);
    access(a, 3'b000, 32'h0, 5'd0, 1'b0, v);
  endtask

  initial begin
    #400000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    // R13: reset state
    repeat (3) @(negedge clk);
    readCsr(12'h509, v);  check("R13 cause at reset", v, 32'h0);
    readCsr(12'hC00, v);  check("R13 cycle held at reset", v, 32'h0);
    check("R13 toHost at reset", toHost, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // Vector table walk
    for (int k = 0; k < NV; k++) begin
      access(VECS[k].addr, VECS[k].op, VECS[k].rv, VECS[k].iv, 1'b1, v);
      check($sformatf("R%0d vector %0d", VECS[k].req, k), v, VECS[k].exp);
    end
    check("R11 toHost port", toHost, 32'hCAFE0000);

    // R12: remaining trap registers
    for (int k = 0; k < 4; k++) begin
      logic [11:0] a;
      a = (k == 0) ? 12'h502 : (k == 1) ? 12'h503 : (k == 2) ? 12'h508 : 12'h509;
      access(a, 3'b001, 32'h10000000 * (k + 1) + 32'h3C, 5'd0, 1'b1, v);
      check("R12 trap reg before write", v, 32'h0);
      readCsr(a, v);
      check("R12 trap reg readback", v, 32'h10000000 * (k + 1) + 32'h3C);
    end

    // R6: cycle counter
    readCsr(12'hC00, v);
    repeat (9) @(posedge clk);
    readCsr(12'hC00, v2);
    check("R6 cycle delta", v2 - v, 32'd10);
    access(12'hC00, 3'b001, 32'h0, 5'd0, 1'b1, v);
    readCsr(12'hC00, v2);
    check("R9 cycle ignores write", v2 - v, 32'd1);
    readCsr(12'hC80, v);  check("R6 cycle high", v, 32'h0);

    // R8: retired counter
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); retire = 1'b1;
      @(negedge clk); retire = 1'b0;
    end
    readCsr(12'hC02, v);  check("R8 instret low", v, 32'd3);
    access(12'hC02, 3'b101, 32'h0, 5'h1F, 1'b1, v);
    readCsr(12'hC02, v);  check("R9 instret ignores write", v, 32'd3);
    readCsr(12'hC82, v);  check("R8 instret high", v, 32'h0);

    // R7: timer ticks, one per rising edge even when held high
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); timerIn = 1'b1;
      repeat (8) @(negedge clk);
      timerIn = 1'b0;
      repeat (6) @(negedge clk);
    end
    readCsr(12'hC01, v);  check("R7 time low", v, 32'd2);
    readCsr(12'hC81, v);  check("R7 time high", v, 32'h0);

    // R11: host delivery
    @(negedge clk); hostValid = 1'b1; hostData = 32'h11223344;
    @(negedge clk); hostValid = 1'b0;
    readCsr(12'h51F, v);  check("R11 fromhost load", v, 32'h11223344);
    // R5: zero-operand set/clear leaves from-host untouched
    access(12'h51F, 3'b010, 32'h0, 5'd0, 1'b1, v);
    access(12'h51F, 3'b111, 32'hFFFFFFFF, 5'd0, 1'b1, v);
    readCsr(12'h51F, v);  check("R5 fromhost untouched", v, 32'h11223344);
    // R11: host wins over software write in the same cycle
    hostValid = 1'b1; hostData = 32'h99887766;
    access(12'h51F, 3'b001, 32'h0BADBEEF, 5'd0, 1'b1, v);
    hostValid = 1'b0;
    readCsr(12'h51F, v);  check("R11 host priority", v, 32'h99887766);
    // R11: software write to from-host when host idle
    access(12'h51F, 3'b001, 32'h00C0FFEE, 5'd0, 1'b1, v);
    readCsr(12'h51F, v);  check("R11 fromhost sw write", v, 32'h00C0FFEE);

    // R13: reset mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    readCsr(12'h500, v);  check("R13 scratch reset", v, 32'h0);
    readCsr(12'hC02, v);  check("R13 instret reset", v, 32'h0);
    readCsr(12'h50B, v);  check("R13 hart constant", v, HART);
    check("R13 toHost reset", toHost, 32'h0);
    @(negedge clk); rstN = 1'b1;

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule